// File: doc/BRIEF.md
# Dual-Bank Pointer Address Generator

This block turns operand requests into addresses for two small on-chip data RAM banks. It holds eight 8-bit pointer registers. The upper index bit of a pointer selects its bank, so pointers 0 to 3 reach bank 0 and pointers 4 to 7 reach bank 1. Each request names a pointer, an addressing form and a 2-bit modifier field. The block returns one of three things: the pointer itself, a RAM address taken from the pointer, or a RAM address taken from a word that the RAM returns at the pointer address.

In each bank the top pointer (index 3 and index 7) is a fixed base tied to word 0. For these two pointers the 2-bit field is a short word offset, not a post-modifier. The other six pointers can be loaded from an immediate value, and each access can step them after the address has gone out. The RAM has an asynchronous read port. The low byte of the word it returns is fed back on `ramWord` in the same cycle that `ramAddr` is presented.

Top module: `dual_bank_agu`

## Requirements
- R1: The bank driven on `ramBank` for any RAM access is bit 2 of the requesting pointer index: 0 for pointers 0-3 and 1 for pointers 4-7.
- R2: A request with mode 0 (direct) raises `ptrValid` for one cycle, in the cycle after acceptance, with `ptrData` equal to the pointer's effective value. `ramEn` stays low.
- R3: A request with mode 1 or mode 3 (single indirection) raises `ramEn` and `addrValid` together for one cycle, in the cycle after acceptance, with `ramAddr` equal to the pointer's effective value.
- R4: A request with mode 2 (double indirection) first spends one cycle with `ramEn`=1, `addrValid`=0, `busy`=1 and `ramAddr` equal to the pointer's effective value. In the next cycle `ramEn`=1, `addrValid`=1 and `busy`=0, with `ramAddr` equal to the `ramWord` seen during the first cycle, and the bank is unchanged.
- R5: Modifier code 0 leaves a writable pointer unchanged. Code 1 adds 1, code 2 subtracts 1 and code 3 adds 1, all modulo 256. The address issued uses the value from before the change, and the new value shows on the next access.
- R6: Asserting `ldValid` writes `ldData` into writable pointer `ldPtr` at the clock edge. A load and a post-modification of the same pointer at the same edge leave the loaded value.
- R7: Pointers 3 and 7 always have an effective value equal to the 2-bit modifier field, giving word 0 to 3 of their bank, in every mode. No access changes them.
- R8: A load aimed at pointer 3 or 7 changes nothing and raises `ldErr` for exactly one cycle, in the cycle after the load.
- R9: A request presented while `busy` is high is ignored. It produces no output and does not modify any pointer.
- R10: After reset `ramEn`, `addrValid`, `ptrValid`, `busy` and `ldErr` are low and every writable pointer reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Operand request strobe |
| reqPtr | input | 3 | Pointer index of the request |
| reqMode | input | 2 | 0 direct, 1 or 3 single indirection, 2 double indirection |
| reqMod | input | 2 | Post-modifier code, or word offset for pointers 3 and 7 |
| ldValid | input | 1 | Immediate load strobe |
| ldPtr | input | 3 | Pointer index to load |
| ldData | input | 8 | Immediate load value |
| ramWord | input | 8 | Low byte of the RAM word at the presented address |
| ramEn | output | 1 | RAM access strobe |
| ramBank | output | 1 | Bank select |
| ramAddr | output | 8 | RAM word address |
| addrValid | output | 1 | Final operand address present |
| ptrValid | output | 1 | Direct pointer value present |
| ptrData | output | 8 | Direct pointer value |
| busy | output | 1 | Double-indirection lookup in progress |
| ldErr | output | 1 | Rejected load pulse |

## Verification
A corrupted pointer register shows up on the next access through that pointer. It appears as a wrong `ramAddr` or `ptrData` one cycle after the request. A wrong modifier result therefore stays hidden until the same pointer is used again, so the bench always follows a modifying access with another access to that pointer. A fault in the lookup sequencing shows up within two cycles. It can appear as a missing or extra RAM strobe, `addrValid` on the wrong step, or a final address that does not match the word the RAM model returned. A dropped busy guard shows up as an unexpected output while a lookup is in progress.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT     = 2'd0,
    MODE_SINGLE     = 2'd1,
    MODE_DOUBLE     = 2'd2,
    MODE_SINGLE_ALT = 2'd3
  } agu_mode_e;

  typedef enum logic [1:0] {
    MOD_KEEP    = 2'd0,
    MOD_INC     = 2'd1,
    MOD_DEC     = 2'd2,
    MOD_INC_ALT = 2'd3
  } agu_mod_e;

  // Strobes from the sequencer to the pointer datapath
  typedef struct packed {
    logic latchAddr;   // capture the effective address for a RAM access
    logic reportPtr;   // present the effective value on the direct port
    logic finalNow;    // the address issued at this edge is the final one
    logic fetchSecond; // replace the address with the word read back
    logic applyMod;    // post-modify the requesting pointer
    logic rejectLoad;  // a load aimed at a fixed pointer
  } agu_strobe_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqMode,
  input  logic             ldValid,
  input  logic [IDX_W-1:0] ldPtr,
  output agu_strobe_t      strobes,
  output logic             busy
);
  localparam int SLOT_W = IDX_W - 1;

  logic stepTwo;
  logic accept;
  logic ldFixed;
  agu_mode_e modeIn;

  assign modeIn  = agu_mode_e'(reqMode);
  assign accept  = reqValid && !stepTwo;
  assign ldFixed = (ldPtr[SLOT_W-1:0] == {SLOT_W{1'b1}});

  always_comb begin
    strobes             = '0;
    strobes.latchAddr   = accept && (modeIn != MODE_DIRECT);
    strobes.reportPtr   = accept && (modeIn == MODE_DIRECT);
    strobes.finalNow    = (accept && (modeIn == MODE_SINGLE || modeIn == MODE_SINGLE_ALT))
                          || stepTwo;
    strobes.fetchSecond = stepTwo;
    strobes.applyMod    = accept;
    strobes.rejectLoad  = ldValid && ldFixed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepTwo <= 1'b0;
    else       stepTwo <= accept && (modeIn == MODE_DOUBLE);
  end

  assign busy = stepTwo;

endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int NUM_PTR = 8,
  parameter int PTR_W   = 8,
  parameter int IDX_W   = $clog2(NUM_PTR)
) (
  input  logic             clk,
  input  logic             rstN,
  input  agu_strobe_t      strobes,
  input  logic [IDX_W-1:0] reqPtr,
  input  logic [1:0]       reqMod,
  input  logic             ldValid,
  input  logic [IDX_W-1:0] ldPtr,
  input  logic [PTR_W-1:0] ldData,
  input  logic [PTR_W-1:0] ramWord,
  output logic             ramEn,
  output logic             ramBank,
  output logic [PTR_W-1:0] ramAddr,
  output logic             addrValid,
  output logic             ptrValid,
  output logic [PTR_W-1:0] ptrData,
  output logic             ldErr
);
  localparam int SLOT_W   = IDX_W - 1;
  localparam int PER_BANK = NUM_PTR / 2;

  logic [PTR_W-1:0] ptrVal [NUM_PTR];
  logic             reqFixed;
  logic [PTR_W-1:0] effAddr;

  assign reqFixed = (reqPtr[SLOT_W-1:0] == {SLOT_W{1'b1}});
  assign effAddr  = reqFixed ? {{(PTR_W-2){1'b0}}, reqMod} : ptrVal[reqPtr];

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] v, input logic [1:0] code);
    case (agu_mod_e'(code))
      MOD_INC, MOD_INC_ALT: stepPtr = v + 1'b1;
      MOD_DEC:              stepPtr = v - 1'b1;
      default:              stepPtr = v;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_PTR; g++) begin : gPtr
    if ((g % PER_BANK) == PER_BANK - 1) begin : gFixed
      assign ptrVal[g] = '0;
    end else begin : gLive
      logic [PTR_W-1:0] value;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          value <= '0;
        end else if (ldValid && ldPtr == IDX_W'(g)) begin
          value <= ldData;
        end else if (strobes.applyMod && reqPtr == IDX_W'(g)) begin
          value <= stepPtr(value, reqMod);
        end
      end
      assign ptrVal[g] = value;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramEn     <= 1'b0;
      ramBank   <= 1'b0;
      ramAddr   <= '0;
      addrValid <= 1'b0;
      ptrValid  <= 1'b0;
      ptrData   <= '0;
      ldErr     <= 1'b0;
    end else begin
      ramEn     <= strobes.latchAddr || strobes.fetchSecond;
      addrValid <= strobes.finalNow;
      ptrValid  <= strobes.reportPtr;
      ldErr     <= strobes.rejectLoad;
      if (strobes.fetchSecond) begin
        ramAddr <= ramWord;
      end else if (strobes.latchAddr) begin
        ramAddr <= effAddr;
        ramBank <= reqPtr[IDX_W-1];
      end
      if (strobes.reportPtr) ptrData <= effAddr;
    end
  end

endmodule

// File: rtl/dual_bank_agu.sv
module dual_bank_agu
  import agu_pkg::*;
#(
  parameter int NUM_PTR = 8,
  parameter int PTR_W   = 8,
  parameter int IDX_W   = $clog2(NUM_PTR)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [IDX_W-1:0] reqPtr,
  input  logic [1:0]       reqMode,
  input  logic [1:0]       reqMod,
  input  logic             ldValid,
  input  logic [IDX_W-1:0] ldPtr,
  input  logic [PTR_W-1:0] ldData,
  input  logic [PTR_W-1:0] ramWord,
  output logic             ramEn,
  output logic             ramBank,
  output logic [PTR_W-1:0] ramAddr,
  output logic             addrValid,
  output logic             ptrValid,
  output logic [PTR_W-1:0] ptrData,
  output logic             busy,
  output logic             ldErr
);
  agu_strobe_t strobes;

  agu_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .ldValid(ldValid), .ldPtr(ldPtr), .strobes(strobes), .busy(busy)
  );

  agu_datapath #(.NUM_PTR(NUM_PTR), .PTR_W(PTR_W), .IDX_W(IDX_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqPtr(reqPtr), .reqMod(reqMod),
    .ldValid(ldValid), .ldPtr(ldPtr), .ldData(ldData), .ramWord(ramWord),
    .ramEn(ramEn), .ramBank(ramBank), .ramAddr(ramAddr), .addrValid(addrValid),
    .ptrValid(ptrValid), .ptrData(ptrData), .ldErr(ldErr)
  );

endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int PTR_W = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [IDX_W-1:0] reqPtr,
  input logic [1:0]       reqMode,
  input logic [1:0]       reqMod,
  input logic             ldValid,
  input logic [IDX_W-1:0] ldPtr,
  input logic [PTR_W-1:0] ramWord,
  input logic             ramEn,
  input logic             ramBank,
  input logic [PTR_W-1:0] ramAddr,
  input logic             addrValid,
  input logic             ptrValid,
  input logic             busy,
  input logic             ldErr
);
  localparam int SLOT_W = IDX_W - 1;

  assert_final_strobed_R3: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> ramEn);

  assert_bank_follows_index_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqMode != 2'd0) |=> (ramBank == $past(reqPtr[IDX_W-1])));

  assert_direct_no_ram_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqMode == 2'd0) |=> (ptrValid && !ramEn));

  assert_double_first_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqMode == 2'd2) |=> (busy && ramEn && !addrValid));

  assert_double_second_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy && ramEn && addrValid && ramAddr == $past(ramWord) && $stable(ramBank)));

  assert_fixed_offset_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqMode == 2'd1 && reqPtr[SLOT_W-1:0] == {SLOT_W{1'b1}})
      |=> (ramAddr == PTR_W'($past(reqMod))));

  assert_reject_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && ldPtr[SLOT_W-1:0] == {SLOT_W{1'b1}}) |=> ldErr);

  assert_no_busy_request_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid && reqMode == 2'd0) |=> !ptrValid);

endmodule

bind dual_bank_agu agu_checker #(.PTR_W(PTR_W), .IDX_W(IDX_W)) uChecker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPtr(reqPtr), .reqMode(reqMode),
  .reqMod(reqMod), .ldValid(ldValid), .ldPtr(ldPtr), .ramWord(ramWord), .ramEn(ramEn),
  .ramBank(ramBank), .ramAddr(ramAddr), .addrValid(addrValid), .ptrValid(ptrValid),
  .busy(busy), .ldErr(ldErr)
);

// File: tb/dual_bank_agu_test.sv
`timescale 1ns/1ps
module dual_bank_agu_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqPtr = '0;
  logic [1:0] reqMode = '0;
  logic [1:0] reqMod = '0;
  logic       ldValid = 1'b0;
  logic [2:0] ldPtr = '0;
  logic [7:0] ldData = '0;
  logic [7:0] ramWord;
  logic       ramEn, ramBank, addrValid, ptrValid, busy, ldErr;
  logic [7:0] ramAddr, ptrData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // Asynchronous RAM model: returned byte depends on bank and address
  assign ramWord = ramAddr ^ (ramBank ? 8'h3C : 8'hC3);

  dual_bank_agu uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPtr(reqPtr), .reqMode(reqMode),
    .reqMod(reqMod), .ldValid(ldValid), .ldPtr(ldPtr), .ldData(ldData), .ramWord(ramWord),
    .ramEn(ramEn), .ramBank(ramBank), .ramAddr(ramAddr), .addrValid(addrValid),
    .ptrValid(ptrValid), .ptrData(ptrData), .busy(busy), .ldErr(ldErr)
  );

  typedef struct packed {
    logic       direct;
    logic       bank;
    logic [7:0] addr;
    logic       fin;
    logic       bsy;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  logic [7:0] model [8];

  function automatic bit isFixed(input logic [2:0] p);
    return p[1:0] == 2'b11;
  endfunction

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per output event
  always @(negedge clk) begin
    if (rstN && !finished && (ramEn || ptrValid)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9 unexpected output", $sformatf("ramEn=%0b ptrValid=%0b", ramEn, ptrValid), "none");
      end else begin
        exp_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (e.direct)
          check(ptrValid && !ramEn && ptrData == e.addr, t,
                $sformatf("pv=%0b en=%0b d=%02h", ptrValid, ramEn, ptrData),
                $sformatf("pv=1 en=0 d=%02h", e.addr));
        else
          check(ramEn && !ptrValid && ramBank == e.bank && ramAddr == e.addr &&
                addrValid == e.fin && busy == e.bsy, t,
                $sformatf("en=%0b b=%0b a=%02h v=%0b busy=%0b", ramEn, ramBank, ramAddr, addrValid, busy),
                $sformatf("en=1 b=%0b a=%02h v=%0b busy=%0b", e.bank, e.addr, e.fin, e.bsy));
      end
    end
  end

  // Driver: one request, with an optional load in the same cycle and an optional poke while busy
  task automatic drive(input logic [2:0] p, input logic [1:0] m, input logic [1:0] md,
                       input bit doLd, input logic [2:0] lp, input logic [7:0] ld,
                       input bit poke, input string tag);
    logic [7:0] eff;
    exp_t e;
    eff = isFixed(p) ? {6'd0, md} : model[p];
    e = '0;
    e.bank = p[2];
    e.addr = eff;
    if (m == 2'd0) begin
      e.direct = 1'b1;
      expQ.push_back(e); tagQ.push_back(tag);
    end else if (m == 2'd2) begin
      e.bsy = 1'b1;
      expQ.push_back(e); tagQ.push_back({tag, " step1"});
      e.bsy = 1'b0; e.fin = 1'b1;
      e.addr = eff ^ (p[2] ? 8'h3C : 8'hC3);
      expQ.push_back(e); tagQ.push_back({tag, " step2"});
    end else begin
      e.fin = 1'b1;
      expQ.push_back(e); tagQ.push_back(tag);
    end
    if (!isFixed(p) && !(doLd && lp == p)) begin
      if (md == 2'd2) model[p] = model[p] - 8'd1;
      else if (md != 2'd0) model[p] = model[p] + 8'd1;
    end
    if (doLd && !isFixed(lp)) model[lp] = ld;
    @(negedge clk);
    reqValid = 1'b1; reqPtr = p; reqMode = m; reqMod = md;
    ldValid = doLd; ldPtr = lp; ldData = ld;
    @(negedge clk);
    ldValid = 1'b0;
    if (poke) begin
      reqPtr = 3'd0; reqMode = 2'd0; reqMod = 2'd1;
    end else reqValid = 1'b0;
    if (m == 2'd2) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  task automatic req(input logic [2:0] p, input logic [1:0] m, input logic [1:0] md, input string tag);
    drive(p, m, md, 1'b0, 3'd0, 8'd0, 1'b0, tag);
  endtask

  task automatic load(input logic [2:0] lp, input logic [7:0] ld, input string tag);
    bit fixed;
    fixed = isFixed(lp);
    if (!fixed) model[lp] = ld;
    @(negedge clk);
    ldValid = 1'b1; ldPtr = lp; ldData = ld;
    @(negedge clk);
    ldValid = 1'b0;
    check(ldErr == fixed, tag, $sformatf("ldErr=%0b", ldErr), $sformatf("ldErr=%0b", fixed));
    @(negedge clk);
    check(ldErr == 1'b0, {tag, " pulse end"}, $sformatf("ldErr=%0b", ldErr), "ldErr=0");
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", "timeout", "completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!ramEn && !addrValid && !ptrValid && !busy && !ldErr, "R10 reset outputs",
          $sformatf("%0b%0b%0b%0b%0b", ramEn, addrValid, ptrValid, busy, ldErr), "00000");
    req(3'd0, 2'd0, 2'd0, "R10 ptr0 zero");
    req(3'd5, 2'd0, 2'd0, "R10 ptr5 zero");

    // R6 loads, R2 direct read-back
    load(3'd1, 8'h40, "R6 load ptr1");
    load(3'd6, 8'h81, "R6 load ptr6");
    req(3'd1, 2'd0, 2'd0, "R2 direct ptr1");
    // R3 single indirection, R1 banks, R5 modifiers
    req(3'd1, 2'd1, 2'd1, "R3 single ptr1 inc");
    req(3'd1, 2'd3, 2'd2, "R5 mode3 after inc, dec");
    req(3'd1, 2'd1, 2'd3, "R5 after dec, alt inc");
    req(3'd1, 2'd0, 2'd0, "R5 ptr1 after alt inc");
    req(3'd6, 2'd1, 2'd0, "R1 bank1 ptr6");
    req(3'd6, 2'd0, 2'd0, "R5 ptr6 kept");
    // R5 wrap
    load(3'd2, 8'hFF, "R6 load ptr2");
    req(3'd2, 2'd1, 2'd1, "R5 wrap up issue");
    req(3'd2, 2'd1, 2'd2, "R5 wrap up result, dec");
    req(3'd2, 2'd0, 2'd0, "R5 wrap down result");
    // R4 double indirection, both banks
    req(3'd0, 2'd2, 2'd1, "R4 double bank0");
    req(3'd4, 2'd2, 2'd2, "R4 double bank1");
    req(3'd4, 2'd0, 2'd0, "R5 ptr4 after double dec");
    // R7 fixed pointers
    for (int k = 0; k < 4; k++) begin
      req(3'd3, 2'd1, 2'(k), $sformatf("R7 fixed ptr3 offset %0d", k));
      req(3'd7, 2'd2, 2'(k), $sformatf("R7 fixed ptr7 double offset %0d", k));
    end
    req(3'd7, 2'd0, 2'd2, "R7 fixed ptr7 direct");
    // R8 rejected loads
    load(3'd3, 8'h99, "R8 load ptr3");
    load(3'd7, 8'h55, "R8 load ptr7");
    req(3'd3, 2'd0, 2'd0, "R8 ptr3 unchanged");
    req(3'd7, 2'd1, 2'd0, "R8 ptr7 unchanged");
    // R6 load wins over post-modify
    drive(3'd5, 2'd1, 2'd1, 1'b1, 3'd5, 8'h20, 1'b0, "R6 same-cycle access");
    req(3'd5, 2'd0, 2'd0, "R6 load beats modify");
    // R9 request during busy
    drive(3'd2, 2'd2, 2'd0, 1'b0, 3'd0, 8'd0, 1'b1, "R9 double with poke");
    req(3'd0, 2'd0, 2'd0, "R9 ptr0 untouched by poke");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R9 queue drained", $sformatf("%0d", expQ.size()), "0");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule